// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block connects a clocked system to an external asynchronous static RAM of 512K words by 16 bits, split into two 8-bit byte lanes. The system side uses a level request held until a one-cycle acknowledge. The request carries a word address, a read/write flag, write data and a per-lane byte mask. The memory side drives a low-active and a high-active chip enable, write enable, output enable, one low-active enable per byte lane, the address, and a data bus split into output, input and a driver-enable for the pad tri-state.

All memory timing comes from counting clock cycles. Each minimum time of the selected speed grade is rounded up to whole clock periods. A write opens with every qualifying strobe active and is closed by write enable alone. Address, lanes and data stay on the pins for at least one more cycle. After a read, the data driver stays off for a turnaround window, so the memory can release the bus before write data is driven. While idle the controller parks with the chip deselected and every strobe inactive.

Top module: `asram_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, the memory pins are parked. The low-active chip enable is 1 and the high-active chip enable is 0. Write enable, output enable and both lane enables are 1. The data driver is off and ack is 0.
- R2: A read asserts both chip enables and output enable, keeps write enable high, and holds the address for N_RD = 11 cycles (55 ns grade, 5 ns clock). rdata is captured on the edge that ends this count. ack is visible N_RD cycles after the accepting edge.
- R3: Mask bit 0 selects lane bits 7:0 and mask bit 1 selects bits 15:8. In rdata, a lane whose mask bit is 0 reads as zero, whatever is on the bus.
- R4: A write holds write enable low for exactly N_PWE = 9 cycles. During that time the chip is selected, output enable is high and the data driver is on. Only lanes whose mask bit is 1 have their lane enable low, so only those lanes are written.
- R5: The write is ended by write enable rising. Chip enables, lane enables, address and data stay unchanged for at least one more cycle. The whole write spans N_WC = 11 cycles, and ack is visible N_WC cycles after the accepting edge.
- R6: Address and write data do not change while write enable is low.
- R7: The data driver is never on while output enable is low.
- R8: After a read, the data driver stays off and no write starts before the (N_TURN+1)-th edge after output enable returned high (N_TURN = 4).
- R9: A request with an all-zero mask is acknowledged one cycle after it is seen, with no memory strobe activity and no change to memory.
- R10: ack is high for exactly one cycle per request. A request is taken only while idle, and its fields are captured on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | 2 | Lane enables, active low, bit 0 = lower lane |
| mem_addr | output | 19 | Memory address |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Data pad driver enable |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
With a 5 ns clock, a read or write is acknowledged 11 cycles after the accepting edge and an empty-mask request 1 cycle after it. A write that follows a read is delayed until 5 edges after the read's acknowledge edge. The bench raises a request just after a falling edge and counts rising edges until it first sees ack at a falling edge, so the expected counts are 12, 2-free single-cycle 1, and 15 for the write-after-read case. Pin monitors sample at falling edges, after every registered output has settled, and measure write-enable and output-enable widths in whole cycles.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WPULSE,
    ST_WHOLD
  } seq_state_e;

  // minimum times of one speed grade, in ns
  typedef struct packed {
    int unsigned wr_cycle;
    int unsigned we_pulse;
    int unsigned addr_to_end;
    int unsigned data_to_end;
    int unsigned addr_access;
    int unsigned rd_cycle;
    int unsigned oe_access;
    int unsigned bus_release;
  } grade_ns_t;

  function automatic grade_ns_t grade_times(input int unsigned grade);
    grade_ns_t t;
    if (grade >= 70) begin
      t.wr_cycle    = 70;
      t.we_pulse    = 60;
      t.addr_to_end = 60;
      t.data_to_end = 30;
      t.addr_access = 70;
      t.rd_cycle    = 70;
      t.oe_access   = 35;
      t.bus_release = 25;
    end else begin
      t.wr_cycle    = 55;
      t.we_pulse    = 45;
      t.addr_to_end = 45;
      t.data_to_end = 25;
      t.addr_access = 55;
      t.rd_cycle    = 55;
      t.oe_access   = 25;
      t.bus_release = 20;
    end
    return t;
  endfunction

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq #(
  parameter int N_RD   = 11,
  parameter int N_PWE  = 9,
  parameter int N_HOLD = 2,
  parameter int N_TURN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic req_we,
  input  logic req_mask_any,
  output logic accept,
  output logic capture,
  output logic sel_nxt,
  output logic ce_n,
  output logic ce2,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe,
  output logic ack
);
  import asram_pkg::*;

  localparam int N_MAX  = (N_RD > N_PWE) ? ((N_RD > N_HOLD) ? N_RD : N_HOLD)
                                         : ((N_PWE > N_HOLD) ? N_PWE : N_HOLD);
  localparam int CNT_W  = $clog2(N_MAX + 1);
  localparam int TURN_W = $clog2(N_TURN + 2);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [TURN_W-1:0] turn_q;
  logic              fin, skip, cnt_zero;
  logic              ce_n_q, ce2_q, we_n_q, oe_n_q, dq_oe_q, ack_q;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    accept  = 1'b0;
    capture = 1'b0;
    fin     = 1'b0;
    skip    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          if (!req_mask_any) begin
            skip = 1'b1;
          end else if (!req_we) begin
            accept  = 1'b1;
            state_d = ST_READ;
            cnt_d   = CNT_W'(N_RD - 1);
          end else if (turn_q == '0) begin
            accept  = 1'b1;
            state_d = ST_WPULSE;
            cnt_d   = CNT_W'(N_PWE - 1);
          end
        end
      end
      ST_READ: begin
        if (cnt_zero) begin
          state_d = ST_IDLE;
          capture = 1'b1;
          fin     = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WPULSE: begin
        if (cnt_zero) begin
          state_d = ST_WHOLD;
          cnt_d   = CNT_W'(N_HOLD - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WHOLD: begin
        if (cnt_zero) begin
          state_d = ST_IDLE;
          fin     = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    sel_nxt = (state_d != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      turn_q  <= '0;
      ce_n_q  <= 1'b1;
      ce2_q   <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ack_q   <= fin | skip;
      if (capture)             turn_q <= TURN_W'(N_TURN);
      else if (turn_q != '0)   turn_q <= turn_q - 1'b1;
      ce_n_q  <= !sel_nxt;
      ce2_q   <= sel_nxt;
      oe_n_q  <= (state_d != ST_READ);
      we_n_q  <= (state_d != ST_WPULSE);
      dq_oe_q <= (state_d == ST_WPULSE) || (state_d == ST_WHOLD);
    end
  end

  assign ce_n  = ce_n_q;
  assign ce2   = ce2_q;
  assign we_n  = we_n_q;
  assign oe_n  = oe_n_q;
  assign dq_oe = dq_oe_q;
  assign ack   = ack_q;

  // pin-level watch counters for the checks below
  logic [CNT_W-1:0]  wlow_q;
  logic [TURN_W-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      wlow_q <= '0;
      gap_q  <= TURN_W'(N_TURN + 1);
    end else begin
      if (!we_n_q) wlow_q <= (wlow_q == CNT_W'(N_MAX)) ? wlow_q : wlow_q + 1'b1;
      else         wlow_q <= '0;
      if (!oe_n_q)                           gap_q <= '0;
      else if (gap_q != TURN_W'(N_TURN + 1)) gap_q <= gap_q + 1'b1;
    end
  end

  AST_PARK_QUIET: assert property (@(posedge clk) disable iff (rst)
    ce_n |-> (we_n && oe_n && !dq_oe)); // R1
  AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!ce_n && ce2 && oe_n && dq_oe)); // R4
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (wlow_q == CNT_W'(N_PWE))); // R4
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> oe_n); // R7
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> (gap_q >= TURN_W'(N_TURN + 1))); // R8
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R10

endmodule

// File: rtl/asram_lanes.sv
module asram_lanes #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     accept,
  input  logic                     sel_nxt,
  input  logic                     capture,
  input  logic [LANES-1:0]         req_mask,
  input  logic [LANES*LANE_W-1:0]  req_wdata,
  input  logic [LANES*LANE_W-1:0]  dq_in,
  output logic [LANES-1:0]         lane_n,
  output logic [LANES*LANE_W-1:0]  dq_out,
  output logic [LANES*LANE_W-1:0]  rdata
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic              mask_q;
    logic              lane_n_q;
    logic [LANE_W-1:0] wd_q;
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q   <= 1'b0;
        lane_n_q <= 1'b1;
        wd_q     <= '0;
        rd_q     <= '0;
      end else begin
        if (accept) begin
          mask_q <= req_mask[i];
          wd_q   <= req_wdata[i*LANE_W +: LANE_W];
        end
        lane_n_q <= !(sel_nxt && (accept ? req_mask[i] : mask_q));
        if (capture) rd_q <= mask_q ? dq_in[i*LANE_W +: LANE_W] : '0;
      end
    end

    assign lane_n[i]                  = lane_n_q;
    assign dq_out[i*LANE_W +: LANE_W] = wd_q;
    assign rdata[i*LANE_W +: LANE_W]  = rd_q;

    AST_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
      ($past(capture) && !mask_q) |-> (rd_q == '0)); // R3
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int ADDR_W   = 19,
  parameter int LANE_W   = 8,
  parameter int LANES    = 2,
  parameter int CLK_NS   = 5,
  parameter int GRADE_NS = 55
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req,
  input  logic                     req_we,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [LANES*LANE_W-1:0]  req_wdata,
  input  logic [LANES-1:0]         req_mask,
  output logic                     ack,
  output logic [LANES*LANE_W-1:0]  rdata,
  output logic                     mem_ce_n,
  output logic                     mem_ce2,
  output logic                     mem_we_n,
  output logic                     mem_oe_n,
  output logic [LANES-1:0]         mem_lane_n,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [LANES*LANE_W-1:0]  mem_dq_out,
  output logic                     mem_dq_oe,
  input  logic [LANES*LANE_W-1:0]  mem_dq_in
);
  import asram_pkg::*;

  localparam grade_ns_t TG = grade_times(GRADE_NS);
  localparam int N_WC   = int'(ns_to_cyc(TG.wr_cycle, CLK_NS));
  localparam int N_PWE  = int'(max2(max2(ns_to_cyc(TG.we_pulse, CLK_NS),
                                         ns_to_cyc(TG.addr_to_end, CLK_NS)),
                                    ns_to_cyc(TG.data_to_end, CLK_NS)));
  localparam int N_HOLD = (N_WC > N_PWE) ? (N_WC - N_PWE) : 1;
  localparam int N_RD   = int'(max2(max2(ns_to_cyc(TG.addr_access, CLK_NS),
                                         ns_to_cyc(TG.rd_cycle, CLK_NS)),
                                    ns_to_cyc(TG.oe_access, CLK_NS)));
  localparam int N_TURN = int'(ns_to_cyc(TG.bus_release, CLK_NS));

  logic accept, capture, sel_nxt;
  logic [ADDR_W-1:0] addr_q;

  asram_seq #(
    .N_RD   (N_RD),
    .N_PWE  (N_PWE),
    .N_HOLD (N_HOLD),
    .N_TURN (N_TURN)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req          (req),
    .req_we       (req_we),
    .req_mask_any (|req_mask),
    .accept       (accept),
    .capture      (capture),
    .sel_nxt      (sel_nxt),
    .ce_n         (mem_ce_n),
    .ce2          (mem_ce2),
    .we_n         (mem_we_n),
    .oe_n         (mem_oe_n),
    .dq_oe        (mem_dq_oe),
    .ack          (ack)
  );

  asram_lanes #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_lanes (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .sel_nxt   (sel_nxt),
    .capture   (capture),
    .req_mask  (req_mask),
    .req_wdata (req_wdata),
    .dq_in     (mem_dq_in),
    .lane_n    (mem_lane_n),
    .dq_out    (mem_dq_out),
    .rdata     (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst)         addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end
  assign mem_addr = addr_q;

  AST_WR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R6
  AST_LANES_NEED_CE: assert property (@(posedge clk) disable iff (rst)
    (mem_lane_n != {LANES{1'b1}}) |-> (!mem_ce_n && mem_ce2)); // R1

endmodule

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;

  localparam int CLK_NS = 5;
  localparam int E_PWE  = (45 + CLK_NS - 1) / CLK_NS;
  localparam int E_WC   = (55 + CLK_NS - 1) / CLK_NS;
  localparam int E_RD   = (55 + CLK_NS - 1) / CLK_NS;
  localparam int E_TURN = (20 + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_we = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        ack;
  logic [15:0] rdata;
  logic        mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;
  logic [18:0] mem_addr;
  logic [15:0] mem_dq_out, mem_dq_in;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  asram_ctrl u0 (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask), .ack(ack), .rdata(rdata),
    .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lane_n(mem_lane_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // memory model: 64 words, tagged with the full address
  logic [15:0] mem [64];
  logic [18:0] tag [64];
  logic        rd_sel;
  logic [15:0] rd_word;
  initial for (int i = 0; i < 64; i++) begin mem[i] = '0; tag[i] = 19'h7FFFF; end
  assign rd_sel  = !mem_ce_n && mem_ce2 && !mem_oe_n && mem_we_n;
  assign rd_word = (tag[mem_addr[5:0]] == mem_addr) ? mem[mem_addr[5:0]] : 16'hDEAD;
  assign mem_dq_in = {(rd_sel && !mem_lane_n[1]) ? rd_word[15:8] : 8'hA5,
                      (rd_sel && !mem_lane_n[0]) ? rd_word[7:0]  : 8'h5A};

  // pin monitors, sampled at falling edges
  bit          ov_prev = 0, ack_prev = 0;
  logic [18:0] rec_addr;
  logic [15:0] rec_data;
  logic [1:0]  rec_lanes;
  int          we_low = 0, oe_low = 0, strobe_cyc = 0;
  always @(negedge clk) if (!rst) begin
    bit ov;
    ov = !mem_ce_n && mem_ce2 && !mem_we_n && (mem_lane_n != 2'b11);
    if (ov && !ov_prev) begin
      rec_addr = mem_addr; rec_data = mem_dq_out; rec_lanes = mem_lane_n;
    end else if (ov) begin
      chk(mem_addr == rec_addr && mem_dq_out == rec_data, "R6 addr/data stable",
          {mem_addr[15:0], mem_dq_out}, {rec_addr[15:0], rec_data});
    end
    if (ov_prev && !ov) begin
      chk(!mem_ce_n && mem_ce2 && mem_dq_oe && mem_lane_n == rec_lanes &&
          mem_dq_out == rec_data && mem_addr == rec_addr, "R5 hold after write end",
          {mem_ce_n, mem_ce2, mem_dq_oe, mem_lane_n}, {3'b011, rec_lanes});
      if (!rec_lanes[0]) mem[rec_addr[5:0]][7:0]  = rec_data[7:0];
      if (!rec_lanes[1]) mem[rec_addr[5:0]][15:8] = rec_data[15:8];
      tag[rec_addr[5:0]] = rec_addr;
    end
    ov_prev = ov;
    if (!mem_we_n) we_low++;
    else if (we_low != 0) begin
      chk(we_low == E_PWE, "R4 write pulse width", we_low, E_PWE);
      we_low = 0;
    end
    if (!mem_oe_n) oe_low++;
    else if (oe_low != 0) begin
      chk(oe_low == E_RD, "R2 read strobe width", oe_low, E_RD);
      oe_low = 0;
    end
    if (mem_dq_oe && !mem_oe_n) chk(0, "R7 driver on with output enable low", 1, 0);
    if (ack && ack_prev) chk(0, "R10 ack longer than one cycle", 2, 1);
    ack_prev = ack;
    if (!mem_ce_n || mem_ce2 || !mem_we_n || !mem_oe_n || mem_lane_n != 2'b11) strobe_cyc++;
  end

  task automatic do_req(input bit we, input logic [1:0] mask, input logic [18:0] addr,
                        input logic [15:0] wd, output int n, output logic [15:0] rd);
    @(negedge clk);
    req = 1'b1; req_we = we; req_mask = mask; req_addr = addr; req_wdata = wd;
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (ack || n > 500) break;
    end
    if (n > 500) chk(0, "R10 no ack", 0, 1);
    rd = rdata;
    req = 1'b0; req_we = 1'b0; req_mask = '0; req_addr = '0; req_wdata = '0;
  endtask

  task automatic chk_park(input string rq);
    chk(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_lane_n == 2'b11 &&
        !mem_dq_oe && !ack, rq,
        {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe, ack}, 8'b1011_1100);
  endtask

  // {we, mask[1:0], addr[18:0], wdata[15:0], expected rdata[15:0]}
  localparam logic [53:0] VEC [8] = '{
    {1'b1, 2'b11, 19'h00003, 16'h1234, 16'h0000},
    {1'b1, 2'b11, 19'h7FFFF, 16'hBEEF, 16'h0000},
    {1'b1, 2'b01, 19'h00003, 16'hAAC3, 16'h0000},  // R4 lower lane only
    {1'b1, 2'b10, 19'h7FFFF, 16'h55AA, 16'h0000},  // R4 upper lane only
    {1'b0, 2'b11, 19'h00003, 16'h0000, 16'h12C3},
    {1'b0, 2'b10, 19'h7FFFF, 16'h0000, 16'h5500},  // R3 lower lane masked
    {1'b0, 2'b01, 19'h7FFFF, 16'h0000, 16'h00EF},  // R3 upper lane masked
    {1'b0, 2'b11, 19'h7FFFF, 16'h0000, 16'h55EF}
  };

  initial begin
    repeat (2000 * 20) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, s0;
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    chk_park("R1 park during reset");
    rst = 1'b0;
    @(negedge clk);
    chk_park("R1 park after reset");

    for (int i = 0; i < 8; i++) begin
      logic [53:0] v;
      v = VEC[i];
      do_req(v[53], v[52:51], v[50:32], v[31:16], n, rd);
      if (v[53]) chk(n == E_WC + 1, "R5 write latency", n, E_WC + 1);
      else begin
        chk(n == E_RD + 1, "R2 read latency", n, E_RD + 1);
        chk(rd == v[15:0], (v[52:51] == 2'b11) ? "R2 read data" : "R3 masked lane data",
            rd, v[15:0]);
      end
      @(negedge clk);
      chk_park("R1 park between accesses");
    end

    // R9: empty mask
    s0 = strobe_cyc;
    do_req(1'b1, 2'b00, 19'h00003, 16'hFFFF, n, rd);
    chk(n == 1, "R9 empty mask latency", n, 1);
    chk(strobe_cyc == s0, "R9 no strobe activity", strobe_cyc - s0, 0);
    do_req(1'b0, 2'b11, 19'h00003, 16'h0000, n, rd);
    chk(rd == 16'h12C3, "R9 memory unchanged", rd, 16'h12C3);

    // R8: write right after a read waits for turnaround
    do_req(1'b1, 2'b11, 19'h00005, 16'h0F0F, n, rd);
    chk(n == E_TURN + 1 - 2 + E_WC + 1, "R8 write after read latency", n,
        E_TURN + E_WC);
    do_req(1'b1, 2'b11, 19'h00006, 16'h3C3C, n, rd);
    chk(n == E_WC + 1, "R10 write after write no wait", n, E_WC + 1);
    do_req(1'b0, 2'b11, 19'h00005, 16'h0000, n, rd);
    chk(rd == 16'h0F0F, "R4 full write committed", rd, 16'h0F0F);
    do_req(1'b0, 2'b11, 19'h00006, 16'h0000, n, rd);
    chk(rd == 16'h3C3C, "R10 fields captured at accept", rd, 16'h3C3C);
    @(negedge clk);
    chk_park("R1 park at end");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule